// File: doc/BRIEF.md
# Vectored Interrupt Controller With Stacking

This block collects interrupt requests from eleven sources (USB bus reset, a 128-µs timer tick, a 1.024-ms timer tick, three endpoints on the first device address, two on the second, the hub, the GPIO pins and the I2C engine). It keeps a pending flag per source and picks one request to service. A request is taken only when the per-source enable and the global enable both allow it. When it is taken, the block saves the CPU return state as a two-byte frame in data RAM through its own stack pointer, which grows upward. It then hands the CPU the vector address of the chosen source.

The same stack engine serves three CPU commands. A subroutine call pushes a frame exactly as an interrupt does. A plain return pops a frame and restores only the program counter. An interrupt return pops a frame, restores the program counter and both flags, and then turns the global enable back on. The CPU datapath and the RAM array sit outside the block. The RAM port is byte wide, and its read data arrives one cycle after the read strobe.

Top module: `irq_stack_ctrl`

## Requirements
- R1: After reset the global enable is 0, `busy` is 0, no RAM strobe is active, every pending flag is clear and the stack pointer is 0x00, so the first push writes address 0x00.
- R2: A request pulse sets the source's pending flag even while the source enable or the global enable is off. The flag stays set until the request is serviced, which happens once both enables are 1.
- R3: When several enabled requests are pending, the lowest source index is serviced first. Only that source's pending flag is cleared, and the others remain pending.
- R4: The vector is 2·(i+1) for source index i from 0 to 8 and 2·(i+2) for index 9 (GPIO, 0x0016) and index 10 (I2C, 0x0018). Address 0x0014 is never produced. `vec_valid` is high for one cycle, in the second push cycle.
- R5: Servicing a request clears the global enable. It writes PC[7:0] at the stack pointer and then {C, Z, PC[13:8]} (bit 7 carry, bit 6 zero) at the stack pointer plus one, leaving the pointer two higher.
- R6: `do_call` in an idle cycle pushes the same two-byte frame as an interrupt. It produces no vector and leaves the global enable unchanged.
- R7: `do_reti` reads stack pointer minus one and then stack pointer minus two, one cycle apart, leaving the pointer two lower. In the cycle after the second read it drives `rest_valid` and `rest_flags_valid`, with the PC rebuilt as {high byte[5:0], low byte} and the carry and zero taken from bits 7 and 6 of the high byte. The global enable is 1 from the next cycle.
- R8: `do_ret` pops the frame in the same way, but `rest_flags_valid` stays low and the global enable is left unchanged.
- R9: `sp_load` in an idle cycle replaces the stack pointer with `sp_value`. The pointer has no read path.
- R10: A GPIO pin sets the GPIO pending flag only when its mask bit is 1 and it makes the transition chosen by `gpio_rise` (1 selects low to high, 0 selects high to low).
- R11: `gie_set` turns the global enable on and `gie_clr` turns it off. A servicing cycle overrides `gie_set`, and the final cycle of an interrupt return overrides both.
- R12: While `busy` is high, `do_call`, `do_ret`, `do_reti` and `sp_load` are ignored and no new interrupt is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | N_SRC | Request pulses, one per source |
| src_en | input | N_SRC | Per-source enable |
| gie_set | input | 1 | Turn global enable on |
| gie_clr | input | 1 | Turn global enable off |
| gpio_pins | input | GPIO_W | GPIO pin levels (synchronous) |
| gpio_mask | input | GPIO_W | Per-pin interrupt mask |
| gpio_rise | input | 1 | 1: rising edge, 0: falling edge |
| cpu_pc | input | PC_W | Return address to save |
| cpu_c | input | 1 | Carry flag to save |
| cpu_z | input | 1 | Zero flag to save |
| do_call | input | 1 | Push a frame for a subroutine call |
| do_ret | input | 1 | Pop a frame, restore PC only |
| do_reti | input | 1 | Pop a frame, restore PC and flags, enable interrupts |
| sp_load | input | 1 | Load the stack pointer |
| sp_value | input | AW | Value for the stack pointer |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after `ram_re` |
| vec_valid | output | 1 | Vector is valid |
| vec_addr | output | PC_W | Vector address |
| rest_valid | output | 1 | Restored PC is valid |
| rest_pc | output | PC_W | Restored program counter |
| rest_flags_valid | output | 1 | Restored flags are valid |
| rest_c | output | 1 | Restored carry |
| rest_z | output | 1 | Restored zero |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | A stack sequence is in progress |

## Verification
The hardest situation to reach is several sources pending at once while they cannot be serviced, followed by one service at a time. The stimulus reaches it by clearing the global enable, pulsing three requests in one cycle (plus a masked-in GPIO edge elsewhere), and then granting the global enable once per service. The order of vectors and the set of still-pending flags then become visible at the ports. A second hard case is a command or a pointer load that arrives mid-sequence. The bench issues `do_reti` and `sp_load` during a call's push. The behavioural model expects both to be ignored, and the later `do_ret` must recover the call's own frame.

// File: rtl/irqstk_pkg.sv
package irqstk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_LO,
      ST_PUSH_HI,
      ST_POP_HI,
      ST_POP_LO,
      ST_DONE
   } seq_st_t;

   typedef enum logic [1:0] {
      K_ACK,
      K_CALL,
      K_RET,
      K_RETI
   } seq_kind_t;
endpackage

// File: rtl/irq_gpio_edge.sv
module irq_gpio_edge #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   input  logic [W-1:0] mask,
   input  logic         rise_sel,
   output logic         hit
);
   logic [W-1:0] prev_q;
   logic [W-1:0] edge_v;

   if (W < 1) begin : g_bad_w
      $error("irq_gpio_edge: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins;
   end

   assign edge_v = rise_sel ? (pins & ~prev_q) : (~pins & prev_q);
   assign hit    = |(edge_v & mask);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N  = 11,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  live,
   output logic          any,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx
);
   logic [N:0] seen;

   if (N < 2) begin : g_bad_n
      $error("irq_pick: N must be at least 2");
   end

   assign seen[0] = 1'b0;
   for (genvar g = 0; g < N; g++) begin : g_chain
      assign grant[g]  = live[g] & ~seen[g];
      assign seen[g+1] = seen[g] | live[g];
   end
   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IW'(i);
      end
   end
endmodule

// File: rtl/irq_frame.sv
module irq_frame #(
   parameter int PC_W = 14
) (
   input  logic [PC_W-1:0] pc,
   input  logic            c,
   input  logic            z,
   output logic [7:0]      lo,
   output logic [7:0]      hi,
   input  logic [7:0]      in_lo,
   input  logic [7:0]      in_hi,
   output logic [PC_W-1:0] out_pc,
   output logic            out_c,
   output logic            out_z
);
   localparam int UP_W = 6;
   logic [UP_W-1:0] pc_up;

   if (PC_W < 9 || PC_W > 8 + UP_W) begin : g_bad_pc
      $error("irq_frame: PC_W must lie in 9..14");
   end

   assign pc_up  = UP_W'(pc >> 8);
   assign lo     = pc[7:0];
   assign hi     = {c, z, pc_up};
   assign out_pc = PC_W'({in_hi[UP_W-1:0], in_lo});
   assign out_c  = in_hi[7];
   assign out_z  = in_hi[6];
endmodule

// File: rtl/irq_stack_ctrl.sv
module irq_stack_ctrl #(
   parameter int N_SRC    = 11,
   parameter int GPIO_IDX = 9,
   parameter int RSV_IDX  = 9,
   parameter int GPIO_W   = 8,
   parameter int PC_W     = 14,
   parameter int AW       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_req,
   input  logic [N_SRC-1:0]  src_en,
   input  logic              gie_set,
   input  logic              gie_clr,
   input  logic [GPIO_W-1:0] gpio_pins,
   input  logic [GPIO_W-1:0] gpio_mask,
   input  logic              gpio_rise,
   input  logic [PC_W-1:0]   cpu_pc,
   input  logic              cpu_c,
   input  logic              cpu_z,
   input  logic              do_call,
   input  logic              do_ret,
   input  logic              do_reti,
   input  logic              sp_load,
   input  logic [AW-1:0]     sp_value,
   output logic              ram_we,
   output logic              ram_re,
   output logic [AW-1:0]     ram_addr,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata,
   output logic              vec_valid,
   output logic [PC_W-1:0]   vec_addr,
   output logic              rest_valid,
   output logic [PC_W-1:0]   rest_pc,
   output logic              rest_flags_valid,
   output logic              rest_c,
   output logic              rest_z,
   output logic              gie,
   output logic              busy
);
   import irqstk_pkg::*;

   localparam int IW = $clog2(N_SRC);

   if (GPIO_IDX >= N_SRC) begin : g_bad_gpio
      $error("irq_stack_ctrl: GPIO_IDX out of range");
   end
   if (RSV_IDX > N_SRC) begin : g_bad_rsv
      $error("irq_stack_ctrl: RSV_IDX out of range");
   end
   if (2 * (N_SRC + 1) >= (1 << PC_W)) begin : g_bad_vec
      $error("irq_stack_ctrl: vectors do not fit PC_W");
   end

   seq_st_t   st_q;
   seq_kind_t kind_q;
   logic [N_SRC-1:0] pend_q, live, grant, set_v, clr_v;
   logic             any_live, gpio_hit, idle, cmd_any, take, reti_end;
   logic [IW-1:0]    pick;
   logic [AW-1:0]    sp_q;
   logic [7:0]       save_lo_q, save_hi_q, hi_q, f_lo, f_hi;
   logic [PC_W-1:0]  vec_q;
   logic             gie_q;

   function automatic logic [PC_W-1:0] vec_of(logic [IW-1:0] i);
      int slot;
      slot = int'(i) + 1;
      if (int'(i) >= RSV_IDX) slot = slot + 1;
      return PC_W'(2 * slot);
   endfunction

   irq_gpio_edge #(.W(GPIO_W)) u_gpio (
      .clk(clk), .rst_n(rst_n), .pins(gpio_pins), .mask(gpio_mask),
      .rise_sel(gpio_rise), .hit(gpio_hit)
   );

   assign live = pend_q & src_en;

   irq_pick #(.N(N_SRC), .IW(IW)) u_pick (
      .live(live), .any(any_live), .grant(grant), .idx(pick)
   );

   irq_frame #(.PC_W(PC_W)) u_frame (
      .pc(cpu_pc), .c(cpu_c), .z(cpu_z), .lo(f_lo), .hi(f_hi),
      .in_lo(ram_rdata), .in_hi(hi_q),
      .out_pc(rest_pc), .out_c(rest_c), .out_z(rest_z)
   );

   always_comb begin
      set_v           = src_req;
      set_v[GPIO_IDX] = src_req[GPIO_IDX] | gpio_hit;
   end

   assign idle     = (st_q == ST_IDLE);
   assign cmd_any  = do_call | do_ret | do_reti;
   assign take     = idle & gie_q & any_live & ~cmd_any;
   assign clr_v    = take ? grant : '0;
   assign reti_end = (st_q == ST_DONE) && (kind_q == K_RETI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_v) | set_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gie_q <= 1'b0;
      else if (reti_end) gie_q <= 1'b1;
      else if (take)     gie_q <= 1'b0;
      else if (gie_clr)  gie_q <= 1'b0;
      else if (gie_set)  gie_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         kind_q    <= K_ACK;
         sp_q      <= '0;
         save_lo_q <= '0;
         save_hi_q <= '0;
         hi_q      <= '0;
         vec_q     <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (sp_load) sp_q <= sp_value;
               if (do_reti) begin
                  st_q <= ST_POP_HI; kind_q <= K_RETI;
               end else if (do_ret) begin
                  st_q <= ST_POP_HI; kind_q <= K_RET;
               end else if (do_call || take) begin
                  st_q      <= ST_PUSH_LO;
                  kind_q    <= do_call ? K_CALL : K_ACK;
                  save_lo_q <= f_lo;
                  save_hi_q <= f_hi;
                  vec_q     <= vec_of(pick);
               end
            end
            ST_PUSH_LO: begin
               sp_q <= sp_q + AW'(1);
               st_q <= ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
               sp_q <= sp_q + AW'(1);
               st_q <= ST_IDLE;
            end
            ST_POP_HI: begin
               sp_q <= sp_q - AW'(1);
               st_q <= ST_POP_LO;
            end
            ST_POP_LO: begin
               sp_q <= sp_q - AW'(1);
               hi_q <= ram_rdata;
               st_q <= ST_DONE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ram_we    = (st_q == ST_PUSH_LO) || (st_q == ST_PUSH_HI);
   assign ram_re    = (st_q == ST_POP_HI) || (st_q == ST_POP_LO);
   assign ram_addr  = (ram_re || st_q == ST_DONE) ? sp_q - AW'(1) : sp_q;
   assign ram_wdata = (st_q == ST_PUSH_LO) ? save_lo_q : save_hi_q;
   assign vec_valid = (st_q == ST_PUSH_HI) && (kind_q == K_ACK);
   assign vec_addr  = vec_q;
   assign rest_valid       = (st_q == ST_DONE);
   assign rest_flags_valid = reti_end;
   assign gie  = gie_q;
   assign busy = !idle;
endmodule

// File: rtl/irq_stack_ctrl_chk.sv
module irq_stack_ctrl_chk #(
   parameter int AW   = 8,
   parameter int PC_W = 14
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ram_we,
   input logic            ram_re,
   input logic [AW-1:0]   ram_addr,
   input logic            vec_valid,
   input logic [PC_W-1:0] vec_addr,
   input logic            rest_valid,
   input logic            rest_flags_valid,
   input logic            gie,
   input logic            busy
);
   assert_we_re_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));

   assert_push_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> (ram_addr == $past(ram_addr) + AW'(1)));

   assert_pop_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |=> (ram_addr == $past(ram_addr) - AW'(1)));

   assert_vec_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ($past(ram_we) && !vec_addr[0] && vec_addr != PC_W'(16'h0014)));

   assert_restore_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rest_valid |-> $past(ram_re));

   assert_flags_only_reti_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rest_flags_valid |-> rest_valid);

   assert_reti_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rest_flags_valid |=> gie);

   assert_strobe_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_we, ram_re, rest_valid}) && ((ram_we || ram_re || rest_valid) -> busy));
endmodule

bind irq_stack_ctrl irq_stack_ctrl_chk #(.AW(AW), .PC_W(PC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_re(ram_re),
   .ram_addr(ram_addr), .vec_valid(vec_valid), .vec_addr(vec_addr),
   .rest_valid(rest_valid), .rest_flags_valid(rest_flags_valid),
   .gie(gie), .busy(busy)
);

// File: tb/tb_irq_stack_ctrl.sv
module tb_irq_stack_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [10:0] src_req = '0, src_en = '0;
   logic gie_set = 0, gie_clr = 0;
   logic [7:0] gpio_pins = '0, gpio_mask = '0;
   logic gpio_rise = 1'b1;
   logic [13:0] cpu_pc = '0;
   logic cpu_c = 0, cpu_z = 0;
   logic do_call = 0, do_ret = 0, do_reti = 0, sp_load = 0;
   logic [7:0] sp_value = '0;
   logic ram_we, ram_re, vec_valid, rest_valid, rest_flags_valid, rest_c, rest_z, gie, busy;
   logic [7:0] ram_addr, ram_wdata;
   logic [7:0] ram_rdata = '0;
   logic [13:0] vec_addr, rest_pc;

   always #2.5 clk = ~clk;

   irq_stack_ctrl dut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
      .gie_set(gie_set), .gie_clr(gie_clr), .gpio_pins(gpio_pins),
      .gpio_mask(gpio_mask), .gpio_rise(gpio_rise), .cpu_pc(cpu_pc),
      .cpu_c(cpu_c), .cpu_z(cpu_z), .do_call(do_call), .do_ret(do_ret),
      .do_reti(do_reti), .sp_load(sp_load), .sp_value(sp_value),
      .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .vec_valid(vec_valid),
      .vec_addr(vec_addr), .rest_valid(rest_valid), .rest_pc(rest_pc),
      .rest_flags_valid(rest_flags_valid), .rest_c(rest_c), .rest_z(rest_z),
      .gie(gie), .busy(busy)
   );

   // RAM array outside the block
   logic [7:0] ram [256];
   always @(posedge clk) begin
      if (ram_we) ram[ram_addr] <= ram_wdata;
      if (ram_re) ram_rdata <= ram[ram_addr];
   end

   // behavioural reference model
   int mst = 0, mkind = 0;
   logic [10:0] mpend = '0, mset, mlive, mclr;
   logic [7:0] mpsp = '0, mprev = '0, medges;
   logic mgie = 0, mtake;
   logic [15:0] msave = '0;
   logic [13:0] mvec = '0;
   logic [7:0] mmem [256];
   int ns, nk, w;
   logic ng;
   logic [7:0] np;

   function automatic logic [13:0] exp_vec(int i);
      case (i)
         0: return 14'h0002;  1: return 14'h0004;  2: return 14'h0006;
         3: return 14'h0008;  4: return 14'h000A;  5: return 14'h000C;
         6: return 14'h000E;  7: return 14'h0010;  8: return 14'h0012;
         9: return 14'h0016;  default: return 14'h0018;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mst = 0; mkind = 0; mpend = '0; mpsp = '0; mprev = '0; mgie = 0;
      end else begin
         ns = mst; nk = mkind; ng = mgie; np = mpsp; mclr = '0;
         medges = gpio_rise ? (gpio_pins & ~mprev) : (~gpio_pins & mprev);
         mset = src_req;
         if (|(medges & gpio_mask)) mset[9] = 1'b1;
         mlive = mpend & src_en;
         w = -1;
         for (int i = 10; i >= 0; i--) if (mlive[i]) w = i;
         mtake = (mst == 0) && mgie && (w >= 0) && !do_call && !do_ret && !do_reti;
         if (mst == 5 && mkind == 3) ng = 1;
         else if (mtake) ng = 0;
         else if (gie_clr) ng = 0;
         else if (gie_set) ng = 1;
         case (mst)
            0: begin
               if (sp_load) np = sp_value;
               if (do_reti) begin ns = 3; nk = 3; end
               else if (do_ret) begin ns = 3; nk = 2; end
               else if (do_call) begin ns = 1; nk = 1; msave = {cpu_c, cpu_z, cpu_pc}; end
               else if (mtake) begin
                  ns = 1; nk = 0; msave = {cpu_c, cpu_z, cpu_pc};
                  mvec = exp_vec(w); mclr[w] = 1'b1;
               end
            end
            1: begin mmem[mpsp] = msave[7:0];  np = mpsp + 8'd1; ns = 2; end
            2: begin mmem[mpsp] = msave[15:8]; np = mpsp + 8'd1; ns = 0; end
            3: begin np = mpsp - 8'd1; ns = 4; end
            4: begin np = mpsp - 8'd1; ns = 5; end
            default: ns = 0;
         endcase
         mst = ns; mkind = nk; mgie = ng; mpsp = np;
         mprev = gpio_pins;
         mpend = (mpend & ~mclr) | mset;
      end
   end

   int vecs = 0, bad = 0, cyc = 0;
   string phase = "R1";

   task automatic cmp(string nm, logic [15:0] act, logic [15:0] exp);
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual %h expected %h", phase, nm, act, exp);
      end
   endtask

   always @(negedge clk) begin
      logic e_we, e_re;
      logic [7:0] hb;
      vecs++;
      e_we = (mst == 1 || mst == 2);
      e_re = (mst == 3 || mst == 4);
      hb = mmem[mpsp + 8'd1];
      cmp("ram_we", 16'(ram_we), 16'(e_we));
      cmp("ram_re", 16'(ram_re), 16'(e_re));
      if (e_we || e_re) cmp("ram_addr", 16'(ram_addr), 16'(e_re ? mpsp - 8'd1 : mpsp));
      if (e_we) cmp("ram_wdata", 16'(ram_wdata), 16'(mst == 1 ? msave[7:0] : msave[15:8]));
      cmp("vec_valid", 16'(vec_valid), 16'(mst == 2 && mkind == 0));
      if (mst == 2 && mkind == 0) cmp("vec_addr", 16'(vec_addr), 16'(mvec));
      cmp("rest_valid", 16'(rest_valid), 16'(mst == 5));
      cmp("rest_flags_valid", 16'(rest_flags_valid), 16'(mst == 5 && mkind == 3));
      if (mst == 5) cmp("rest_pc", 16'(rest_pc), 16'({hb[5:0], mmem[mpsp]}));
      if (mst == 5 && mkind == 3) cmp("rest_cz", 16'({rest_c, rest_z}), 16'(hb[7:6]));
      cmp("gie", 16'(gie), 16'(mgie));
      cmp("busy", 16'(busy), 16'(mst != 0));
   end

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++;
         $display("FAIL R12 watchdog: actual still running, expected finished");
         summary();
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_gie;
      gie_set = 1; tick(1); gie_set = 0;
   endtask

   initial begin
      tick(3);
      rst_n = 1;                           // R1: reset values compared each cycle
      tick(3);
      phase = "R11";
      pulse_gie(); tick(2);
      gie_clr = 1; tick(1); gie_clr = 0; tick(2);
      phase = "R1";                        // first push goes to address 0x00
      src_en = '1; cpu_pc = 14'h0123; cpu_c = 0; cpu_z = 1;
      src_req[0] = 1; tick(1); src_req = '0;
      pulse_gie(); tick(8);
      phase = "R9";
      sp_value = 8'h40; sp_load = 1; tick(1); sp_load = 0; tick(2);
      phase = "R2";
      src_en = '0; src_req[2] = 1; tick(1); src_req = '0;
      pulse_gie(); tick(6);                // pending, not serviced
      src_en[2] = 1; cpu_pc = 14'h2A5C; cpu_c = 1; cpu_z = 0; tick(8);
      phase = "R7";
      do_reti = 1; tick(1); do_reti = 0; tick(8);
      phase = "R3";
      gie_clr = 1; tick(1); gie_clr = 0;
      src_en = '1; src_req[7] = 1; src_req[3] = 1; src_req[10] = 1; tick(1); src_req = '0;
      tick(3);
      pulse_gie(); tick(8);
      pulse_gie(); tick(8);
      pulse_gie(); tick(8);
      phase = "R4";
      for (int i = 0; i < 11; i++) begin
         cpu_pc = 14'(16'h1000 + i * 16'h0111); cpu_c = i[0]; cpu_z = i[1];
         src_req[i] = 1; tick(1); src_req = '0;
         pulse_gie(); tick(8);
      end
      phase = "R5";
      sp_value = 8'hFE; sp_load = 1; tick(1); sp_load = 0;
      cpu_pc = 14'h3FFF; cpu_c = 1; cpu_z = 1;
      src_req[8] = 1; tick(1); src_req = '0; pulse_gie(); tick(8);
      phase = "R6";
      pulse_gie();
      cpu_pc = 14'h1357; cpu_c = 0; cpu_z = 1;
      do_call = 1; tick(1); do_call = 0; tick(6);
      phase = "R8";
      do_ret = 1; tick(1); do_ret = 0; tick(6);
      phase = "R10";
      gie_clr = 1; tick(1); gie_clr = 0;
      gpio_mask = 8'h05; gpio_rise = 1;
      gpio_pins = 8'h02; tick(2);          // masked pin rises
      gpio_pins = 8'h00; tick(2);          // falling, wrong polarity
      pulse_gie(); tick(4);
      gpio_pins = 8'h01; tick(2);          // masked-in rising edge
      tick(8);
      gpio_rise = 0; gpio_pins = 8'h05; tick(2);
      pulse_gie(); tick(4);
      gpio_pins = 8'h01; tick(8);          // pin 2 falls
      phase = "R12";
      gie_clr = 1; tick(1); gie_clr = 0;
      sp_value = 8'h20; sp_load = 1; tick(1); sp_load = 0;
      cpu_pc = 14'h0ABC; cpu_c = 1; cpu_z = 0;
      do_call = 1; tick(1); do_call = 0;
      do_reti = 1; sp_load = 1; sp_value = 8'h80; tick(1);
      do_reti = 0; sp_load = 0; tick(6);
      do_ret = 1; tick(1); do_ret = 0; tick(6);
      summary();
      $finish;
   end
endmodule